// File: doc/BRIEF.md
# Programmable GPIO input debounce filter

This block cleans up one general-purpose input before the rest of the chip sees it. The raw pin passes through a synchronizer into the system clock domain. A filter stage then decides when the settled level may move. Time is measured in units of a slow real-time clock, which arrives as a one-cycle enable (`rtc_tick_i`) at 32.768 kHz. A prescaler groups these ticks into units of 2, 8, 512 or 2048 ticks. A 4-bit count sets how many whole units a new level must persist before it is accepted.

Software programs three fields: a stability count, a unit select and a filter mode. They are loaded together by a one-cycle write strobe. Any write restarts the timing and reloads the output from the synchronized pin. In the filtering modes a change in one direction can be let through at once. This keeps short pulses of one polarity intact for level-sensitive consumers. The output also gives a one-cycle strobe on every change of the filtered level.

Top module: `gpio_dbnc_filter`

## Requirements
- R1: After reset is released, `level_o` equals the pin level within three clock edges. `change_o` stays 0 over those edges.
- R2: With mode 2'b00 (bypass), `level_o` follows the pin three clock edges after the pin changes: two synchronizer stages plus the output register.
- R3: A stability count of 0 behaves as bypass in every mode.
- R4: In mode 2'b01 (full filter), a new level is accepted at the clock edge that samples the count×unit-th RTC tick seen while the synchronized pin differs from `level_o`. It is not accepted at any earlier tick.
- R5: In the filtering modes, if the synchronized pin returns to `level_o` before acceptance, the unit prescaler and the unit counter clear, so timing restarts from zero.
- R6: `unit_sel_i` = {large, small} selects the unit length: 2'b00 = 2 ticks, 2'b01 = 8 ticks, 2'b10 = 512 ticks, 2'b11 = 2048 ticks.
- R7: In mode 2'b10 (pass low pulses), a high-to-low change reaches `level_o` with bypass latency. A low-to-high change is filtered as in R4.
- R8: In mode 2'b11 (pass high pulses), a low-to-high change reaches `level_o` with bypass latency. A high-to-low change is filtered as in R4.
- R9: `change_o` is high for exactly the one cycle that follows each clock edge at which `level_o` changes after initialization, and is low at all other times.
- R10: The clock edge that samples `cfg_we_i` high loads all three fields and clears both counters. At that edge `level_o` takes the synchronized pin value without raising `change_o`.
- R11: The maximum count of 15 with 2-tick units accepts a change at the 30th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_tick_i | input | 1 | One-cycle enable per real-time clock period |
| pin_i | input | 1 | Raw, asynchronous pin level |
| cfg_we_i | input | 1 | Loads the three configuration fields |
| cfg_cnt_i | input | 4 | Stability count in units; 0 means no debounce |
| cfg_unit_i | input | 2 | Unit select {large, small} |
| cfg_mode_i | input | 2 | Filter mode: 00 bypass, 01 full filter, 10 pass low, 11 pass high |
| level_o | output | 1 | Filtered level |
| change_o | output | 1 | One-cycle strobe on a change of level_o |

## Verification
Each unit length is exercised with a stable pin change that is checked one tick before acceptance and again at the accepting tick. This separates the correct unit length and count from off-by-one errors in the prescaler or the unit counter. A change that is withdrawn partway through its window, then re-applied, shows whether the timer truly restarts or keeps the ticks it had already counted. Both edge directions are driven in the two pass-through modes, which shows which polarity is immediate and which is filtered. A configuration write made while a change is pending, together with a count of zero, confirms that the output is reloaded without a strobe and that the bypass paths work.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS    = 2'b00,
    MODE_FILTER    = 2'b01,
    MODE_PASS_LOW  = 2'b10,
    MODE_PASS_HIGH = 2'b11
  } dbnc_mode_e;

  typedef struct packed {
    logic [3:0] cnt;
    logic [1:0] unit;
    dbnc_mode_e mode;
  } dbnc_cfg_t;

endpackage

// File: rtl/gpio_dbnc_sync.sv
module gpio_dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dbnc_prescaler.sv
module gpio_dbnc_prescaler #(
  parameter int UNIT_LEN0 = 2,
  parameter int UNIT_LEN1 = 8,
  parameter int UNIT_LEN2 = 512,
  parameter int UNIT_LEN3 = 2048,
  localparam int PW = $clog2(UNIT_LEN3)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       rtc_tick_i,
  input  logic [1:0] unit_sel_i,
  output logic       unit_tick_o
);
  logic [PW-1:0] tick_cnt_q;
  logic [PW-1:0] last_val;

  always_comb begin
    unique case (unit_sel_i)
      2'b00:   last_val = PW'(UNIT_LEN0 - 1);
      2'b01:   last_val = PW'(UNIT_LEN1 - 1);
      2'b10:   last_val = PW'(UNIT_LEN2 - 1);
      default: last_val = PW'(UNIT_LEN3 - 1);
    endcase
  end

  assign unit_tick_o = !clear_i && rtc_tick_i && (tick_cnt_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tick_cnt_q <= '0;
    else if (clear_i || unit_tick_o) tick_cnt_q <= '0;
    else if (rtc_tick_i)             tick_cnt_q <= tick_cnt_q + PW'(1);
  end
endmodule

// File: rtl/gpio_dbnc_core.sv
module gpio_dbnc_core
  import gpio_dbnc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             load_i,
  input  logic             sync_i,
  input  logic             unit_tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  dbnc_mode_e       mode_i,
  output logic             run_o,
  output logic             level_o,
  output logic             change_o
);
  logic [CNT_W-1:0] units_q;
  logic level_q, change_q;
  logic filter_on, differs, fast_path;

  assign filter_on = (mode_i != MODE_BYPASS) && (cnt_i != '0);
  assign differs   = sync_i != level_q;
  assign fast_path = (mode_i == MODE_PASS_LOW  && !sync_i) ||
                     (mode_i == MODE_PASS_HIGH &&  sync_i);
  assign run_o     = !init_i && !load_i && filter_on && differs && !fast_path;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= 1'b0;
      change_q <= 1'b0;
      units_q  <= '0;
    end else if (init_i || load_i) begin
      level_q  <= sync_i;
      change_q <= 1'b0;
      units_q  <= '0;
    end else if (!filter_on || fast_path) begin
      level_q  <= sync_i;
      change_q <= differs;
      units_q  <= '0;
    end else if (!differs) begin
      change_q <= 1'b0;
      units_q  <= '0;
    end else if (unit_tick_i) begin
      if (units_q == cnt_i - CNT_W'(1)) begin
        level_q  <= sync_i;
        change_q <= 1'b1;
        units_q  <= '0;
      end else begin
        change_q <= 1'b0;
        units_q  <= units_q + CNT_W'(1);
      end
    end else begin
      change_q <= 1'b0;
    end
  end

  assign level_o  = level_q;
  assign change_o = change_q;
endmodule

// File: rtl/gpio_dbnc_filter.sv
module gpio_dbnc_filter
  import gpio_dbnc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int UNIT_LEN0   = 2,
  parameter int UNIT_LEN1   = 8,
  parameter int UNIT_LEN2   = 512,
  parameter int UNIT_LEN3   = 2048,
  localparam int INIT_W     = $clog2(SYNC_STAGES + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rtc_tick_i,
  input  logic             pin_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic [1:0]       cfg_unit_i,
  input  logic [1:0]       cfg_mode_i,
  output logic             level_o,
  output logic             change_o
);
  logic             sync_s;
  logic             unit_tick;
  logic             run;
  logic             init_act;
  logic [INIT_W-1:0] init_cnt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       unit_q;
  dbnc_mode_e       mode_q;

  // output tracks the synchronizer until its stages hold real pin data
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       init_cnt_q <= INIT_W'(SYNC_STAGES + 1);
    else if (init_act) init_cnt_q <= init_cnt_q - INIT_W'(1);

  assign init_act = init_cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      unit_q <= 2'b00;
      mode_q <= MODE_BYPASS;
    end else if (cfg_we_i) begin
      cnt_q  <= cfg_cnt_i;
      unit_q <= cfg_unit_i;
      mode_q <= dbnc_mode_e'(cfg_mode_i);
    end
  end

  gpio_dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_s)
  );

  gpio_dbnc_prescaler #(
    .UNIT_LEN0(UNIT_LEN0), .UNIT_LEN1(UNIT_LEN1),
    .UNIT_LEN2(UNIT_LEN2), .UNIT_LEN3(UNIT_LEN3)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!run),
    .rtc_tick_i (rtc_tick_i),
    .unit_sel_i (unit_q),
    .unit_tick_o(unit_tick)
  );

  gpio_dbnc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_act),
    .load_i     (cfg_we_i),
    .sync_i     (sync_s),
    .unit_tick_i(unit_tick),
    .cnt_i      (cnt_q),
    .mode_i     (mode_q),
    .run_o      (run),
    .level_o    (level_o),
    .change_o   (change_o)
  );
endmodule

// File: rtl/gpio_dbnc_chk.sv
module gpio_dbnc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       level_o,
  input logic       change_o,
  input logic       sync_s,
  input logic       unit_tick,
  input logic       init_act,
  input logic [3:0] cnt_q,
  input logic [1:0] mode_q
);
  a_r9_strobe_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> (level_o != $past(level_o)));

  a_r10_write_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !change_o);

  a_r2_bypass_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_act && !cfg_we_i && mode_q == 2'b00) |=> (level_o == $past(sync_s)));

  a_r4_hold_until_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_act && !cfg_we_i && mode_q == 2'b01 && cnt_q != 4'd0 &&
     level_o != sync_s && !unit_tick) |=> $stable(level_o));

  a_r7_low_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_act && !cfg_we_i && mode_q == 2'b10 && level_o && !sync_s)
      |=> (!level_o && change_o));

  a_r8_high_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_act && !cfg_we_i && mode_q == 2'b11 && !level_o && sync_s)
      |=> (level_o && change_o));
endmodule

bind gpio_dbnc_filter gpio_dbnc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .level_o  (level_o),
  .change_o (change_o),
  .sync_s   (sync_s),
  .unit_tick(unit_tick),
  .init_act (init_act),
  .cnt_q    (cnt_q),
  .mode_q   (mode_q)
);

// File: tb/gpio_dbnc_filter_bench.sv
`timescale 1ns/1ps
module gpio_dbnc_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pin = 1'b1;
  logic we = 1'b0;
  logic [3:0] cnt = '0;
  logic [1:0] unit = '0;
  logic [1:0] mode = '0;
  logic level, change;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_dbnc_filter u_gpio_dbnc_filter (
    .clk_i(clk), .rst_ni(rst_n), .rtc_tick_i(tick), .pin_i(pin),
    .cfg_we_i(we), .cfg_cnt_i(cnt), .cfg_unit_i(unit), .cfg_mode_i(mode),
    .level_o(level), .change_o(change)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic cfg(logic [1:0] m, logic [3:0] c, logic [1:0] u);
    @(negedge clk);
    mode = m; cnt = c; unit = u; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // a filtered change: hold for n-1 ticks, then accept at tick n
  task automatic filtered(string req, logic v, int n);
    pin = v;
    idle(4);
    ticks(n - 1);
    chk(req, level, ~v);
    ticks(1);
    chk(req, level, v);
    chk(req, change, 1'b1);
    idle(1);
    chk(req, change, 1'b0);
  endtask

  // an unfiltered change at three-edge latency
  task automatic direct(string req, logic v);
    pin = v;
    idle(2);
    chk(req, level, ~v);
    idle(1);
    chk(req, level, v);
    chk(req, change, 1'b1);
    idle(1);
    chk(req, change, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 no strobe", change, 1'b0);
    end
    chk("R1 level", level, 1'b1);
  endtask

  task automatic t_bypass;
    cfg(2'b00, 4'd5, 2'b00);
    direct("R2 bypass fall", 1'b0);
    direct("R2 bypass rise", 1'b1);
  endtask

  task automatic t_zero;
    cfg(2'b01, 4'd0, 2'b11);
    direct("R3 zero count", 1'b0);
  endtask

  task automatic t_filter;
    cfg(2'b01, 4'd3, 2'b00);
    filtered("R4 filter rise", 1'b1, 6);
  endtask

  task automatic t_restart;
    pin = 1'b0; idle(4);
    ticks(4);
    pin = 1'b1; idle(4);
    chk("R5 level kept", level, 1'b1);
    filtered("R5 restart", 1'b0, 6);
  endtask

  task automatic t_units;
    cfg(2'b01, 4'd2, 2'b01);
    filtered("R6 unit 8", 1'b1, 16);
    cfg(2'b01, 4'd1, 2'b10);
    filtered("R6 unit 512", 1'b0, 512);
    cfg(2'b01, 4'd2, 2'b11);
    filtered("R6 unit 2048", 1'b1, 4096);
  endtask

  task automatic t_max;
    cfg(2'b01, 4'd15, 2'b00);
    filtered("R11 max count", 1'b0, 30);
  endtask

  task automatic t_pass_low;
    cfg(2'b10, 4'd2, 2'b00);
    filtered("R7 rise filtered", 1'b1, 4);
    direct("R7 fall direct", 1'b0);
  endtask

  task automatic t_pass_high;
    cfg(2'b11, 4'd2, 2'b00);
    direct("R8 rise direct", 1'b1);
    filtered("R8 fall filtered", 1'b0, 4);
  endtask

  task automatic t_write;
    cfg(2'b01, 4'd5, 2'b00);
    pin = 1'b1; idle(4);
    ticks(3);
    chk("R10 pending", level, 1'b0);
    @(negedge clk);
    mode = 2'b01; cnt = 4'd1; unit = 2'b00; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R10 loaded", level, 1'b1);
    chk("R9 R10 no strobe", change, 1'b0);
    filtered("R10 new cfg", 1'b0, 2);
  endtask

  initial begin
    t_reset;
    t_bypass;
    t_zero;
    t_filter;
    t_restart;
    t_units;
    t_max;
    t_pass_low;
    t_pass_high;
    t_write;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule